// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a link to a 64-word by 16-bit serial EEPROM that uses a chip select, a shift clock, a serial input and a serial output. A simple command port takes one command at a time. Each command carries an operation, a 6-bit word address and 16 bits of write data. The controller turns the command into a serial frame. It derives the shift clock from the system clock through a parameterised half-period divider and drives chip select and serial data out. For reads it gathers the returned word. For programming commands it reopens chip select after a low gap and polls the ready/busy level.

The controller is a single state machine with seven states. ST_IDLE waits for a command. ST_LEAD keeps CS low for one half period. ST_SHIFT sends the frame. ST_RECV collects read data. ST_GAP closes CS for one half period. ST_POLL watches the ready level. ST_DONE issues the one-cycle completion pulse. Its transitions are:
- ST_IDLE→ST_LEAD on an accepted command.
- ST_LEAD→ST_SHIFT after one half period.
- ST_SHIFT→ST_RECV (read) or ST_SHIFT→ST_GAP (all others) after the last bit's falling edge.
- ST_RECV→ST_GAP after seventeen samples.
- ST_GAP→ST_POLL (programming commands) or ST_GAP→ST_DONE (read, enable and disable).
- ST_POLL→ST_DONE on a ready sample or on timeout.
- ST_DONE→ST_IDLE unconditionally.

A half-period tick generator and a poll watchdog sit beside the state machine. The poll watchdog bounds a programming cycle. Its default of 500,000 clocks is 10 ms at 50 MHz.

Top module: `ee3w_host`

## Requirements
- R1: A command is accepted only in a cycle where `cmd_ready` is high together with `cmd_valid`. A request made while `cmd_ready` is low, including the cycle of `done`, is ignored. Every accepted command produces exactly one single-cycle `done` pulse.
- R2: Each frame raises CS, then sends a start bit of 1, a 2-bit operation field and the 6-bit address, MSB first. Write-word and write-all then add the 16 data bits, MSB first. The `cmd_op` codes are 0 read, 1 write word, 2 erase word, 3 write-enable, 4 write-disable, 5 erase all and 6 write all; code 7 behaves as write-disable. The operation field is 10 for read, 01 for write and 11 for erase. The other commands use 00, and the top two address bits then select the command: 11 enable, 10 erase all, 01 write all, 00 disable. The remaining four address bits are sent as 0.
- R3: Every SK high or low phase while CS is high lasts exactly HALF_CYC clocks, counting the first low phase from the rise of CS. SK is low whenever CS is low.
- R4: While CS stays high, DI changes only in the cycle in which SK falls.
- R5: On a read, the first DO sample after the header is discarded as the leading zero. The next 16 samples form `rd_data`, MSB first. `rd_data` is valid with `done` and holds until the next read completes.
- R6: After write, erase, erase-all or write-all, CS is held low for HALF_CYC clocks and then raised again. DO is then sampled once per half period: 0 means busy and 1 means ready, and a ready sample ends the command.
- R7: If ready is not seen within TIMEOUT_CYC clocks of polling, the command ends with `err_timeout` = 1. `err_timeout` is otherwise 0 at `done`, and it holds its value until the next accepted command.
- R8: CS stays low for at least HALF_CYC clocks between any two CS-high windows.
- R9: Read, write-enable and write-disable end without a polling window, so there is exactly one CS-high window per command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data for write word / write all |
| cmd_ready | output | 1 | High when a command can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| err_timeout | output | 1 | Ready not seen within the polling bound |
| sk | output | 1 | Serial shift clock |
| cs | output | 1 | Chip select, active high |
| di | output | 1 | Serial data to the memory |
| do_in | input | 1 | Serial data and ready/busy from the memory |

## Verification
Two events can meet in one cycle: the completion pulse of one command and the request for the next. The bench holds `cmd_valid` high with a new read from the very cycle in which `done` appears. It then judges that `cmd_ready` is low in that cycle and high in the next. It also judges that the read is carried out once with the right word, that exactly two completion pulses are counted, and that the CS low gap is still met. A second collision checks refusal: a request made mid-frame leaves memory untouched and produces no pulse of its own. The memory model returns the leading zero before read data, and the bench can hold the ready level low to force the timeout path.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int OPF_W   = 2;
    localparam int HDR_W   = 1 + OPF_W + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_WRITE      = 3'd1,
        OP_ERASE      = 3'd2,
        OP_WR_ENABLE  = 3'd3,
        OP_WR_DISABLE = 3'd4,
        OP_ERASE_ALL  = 3'd5,
        OP_WRITE_ALL  = 3'd6,
        OP_RESERVED   = 3'd7
    } ee_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_RECV  = 3'd3,
        ST_GAP   = 3'd4,
        ST_POLL  = 3'd5,
        ST_DONE  = 3'd6
    } ee_state_e;

    // start bit, operation field, address (or sub-command prefix)
    function automatic logic [HDR_W-1:0] frame_header(ee_cmd_e c, logic [ADDR_W-1:0] a);
        logic [ADDR_W-3:0] z;
        z = '0;
        case (c)
            OP_READ:      return {1'b1, 2'b10, a};
            OP_WRITE:     return {1'b1, 2'b01, a};
            OP_ERASE:     return {1'b1, 2'b11, a};
            OP_WR_ENABLE: return {1'b1, 2'b00, 2'b11, z};
            OP_ERASE_ALL: return {1'b1, 2'b00, 2'b10, z};
            OP_WRITE_ALL: return {1'b1, 2'b00, 2'b01, z};
            default:      return {1'b1, 2'b00, 2'b00, z};
        endcase
    endfunction

    function automatic logic is_program(ee_cmd_e c);
        return (c == OP_WRITE) || (c == OP_ERASE) || (c == OP_ERASE_ALL) || (c == OP_WRITE_ALL);
    endfunction

    function automatic logic carries_data(ee_cmd_e c);
        return (c == OP_WRITE) || (c == OP_WRITE_ALL);
    endfunction

endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
    parameter int HALF_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    generate
        if (HALF_CYC > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/ee3w_wdog.sv
module ee3w_wdog #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = arm && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!arm)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ee3w_host.sv
module ee3w_host
    import ee3w_pkg::*;
#(
    parameter int HALF_CYC    = 13,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_timeout,
    output logic              sk,
    output logic              cs,
    output logic              di,
    input  logic              do_in
);
    localparam int BCNT_W  = $clog2(FRAME_W);
    localparam int RCNT_W  = $clog2(DATA_W + 2);
    localparam int SAMPLES = DATA_W + 1;

    ee_state_e           state, nxt;
    ee_cmd_e             op_q;
    logic [FRAME_W-1:0]  sh;
    logic [BCNT_W-1:0]   bcnt;
    logic [RCNT_W-1:0]   rcnt;
    logic [DATA_W-1:0]   rsh;
    logic                sk_q;
    logic                tick;
    logic                expired;
    logic                accept;
    logic                last_bit;
    logic                tick_run;
    logic                ready_seen;

    assign accept     = cmd_valid && (state == ST_IDLE);
    assign last_bit   = carries_data(op_q) ? (bcnt == BCNT_W'(FRAME_W - 1))
                                           : (bcnt == BCNT_W'(HDR_W - 1));
    assign tick_run   = (state != ST_IDLE) && (state != ST_DONE);
    assign ready_seen = tick && do_in;

    ee3w_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_run),
        .tick  (tick)
    );

    ee3w_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state == ST_POLL),
        .expired (expired)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && sk_q && last_bit)
                          nxt = (op_q == OP_READ) ? ST_RECV : ST_GAP;
            ST_RECV:  if (tick && sk_q && (rcnt == RCNT_W'(SAMPLES))) nxt = ST_GAP;
            ST_GAP:   if (tick) nxt = is_program(op_q) ? ST_POLL : ST_DONE;
            ST_POLL:  if (ready_seen || expired) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // frame, clock and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_READ;
            sh          <= '0;
            bcnt        <= '0;
            rcnt        <= '0;
            rsh         <= '0;
            rd_data     <= '0;
            err_timeout <= 1'b0;
            sk_q        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    op_q        <= ee_cmd_e'(cmd_op);
                    sh          <= {frame_header(ee_cmd_e'(cmd_op), cmd_addr),
                                    carries_data(ee_cmd_e'(cmd_op)) ? cmd_wdata : {DATA_W{1'b0}}};
                    bcnt        <= '0;
                    rcnt        <= '0;
                    err_timeout <= 1'b0;
                end
                ST_SHIFT: if (tick) begin
                    if (!sk_q) begin
                        sk_q <= 1'b1;
                    end else begin
                        sk_q <= 1'b0;
                        if (!last_bit) begin
                            sh   <= {sh[FRAME_W-2:0], 1'b0};
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                ST_RECV: if (tick) begin
                    if (!sk_q) begin
                        sk_q <= 1'b1;
                        rcnt <= rcnt + 1'b1;
                        if (rcnt != '0)
                            rsh <= {rsh[DATA_W-2:0], do_in};
                    end else begin
                        sk_q <= 1'b0;
                        if (rcnt == RCNT_W'(SAMPLES))
                            rd_data <= rsh;
                    end
                end
                ST_POLL: if (!ready_seen && expired) err_timeout <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs        = (state == ST_SHIFT) || (state == ST_RECV) || (state == ST_POLL);
        di        = (state == ST_SHIFT) && sh[FRAME_W-1];
        sk        = sk_q;
        cmd_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sk); // R3
    AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sk != $past(sk)) |-> $past(tick)); // R3
    AST_DI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && $past(cs) && (di != $past(di))) |-> $fell(sk)); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(rd_data)); // R5
    AST_POLL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && $past(state) != ST_POLL) |-> $past(!cs)); // R6
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> done); // R7

endmodule

// File: tb/sim_ee3w_host.sv
`timescale 1ns/1ps
module sim_ee3w_host;
    localparam int HALF = 13;
    localparam int TMO  = 3000;
    localparam int BUSY = 600;
    localparam int NV   = 25;

    // {cmd_op, addr, data}
    localparam logic [24:0] VEC [NV] = '{
        {3'd1, 6'd3,  16'h1234}, {3'd2, 6'd4,  16'h0000}, {3'd6, 6'd0,  16'h0F0F},
        {3'd0, 6'd3,  16'h0000}, {3'd0, 6'd4,  16'h0000}, {3'd3, 6'd0,  16'h0000},
        {3'd1, 6'd3,  16'h1234}, {3'd0, 6'd3,  16'h0000}, {3'd2, 6'd10, 16'h0000},
        {3'd0, 6'd10, 16'h0000}, {3'd1, 6'd63, 16'h8001}, {3'd0, 6'd63, 16'h0000},
        {3'd6, 6'd0,  16'h5A5A}, {3'd0, 6'd0,  16'h0000}, {3'd0, 6'd63, 16'h0000},
        {3'd5, 6'd0,  16'h0000}, {3'd0, 6'd7,  16'h0000}, {3'd1, 6'd0,  16'h0000},
        {3'd4, 6'd0,  16'h0000}, {3'd2, 6'd0,  16'h0000}, {3'd0, 6'd0,  16'h0000},
        {3'd3, 6'd0,  16'h0000}, {3'd7, 6'd0,  16'h0000}, {3'd1, 6'd5,  16'hAAAA},
        {3'd0, 6'd5,  16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [5:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic cmd_ready, done, err_timeout, sk, cs, di, do_in;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    ee3w_host #(.HALF_CYC(HALF), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .done(done), .rd_data(rd_data), .err_timeout(err_timeout),
        .sk(sk), .cs(cs), .di(di), .do_in(do_in)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'hC3A0 ^ 16'(i * 263);
    endfunction

    // ---------------- memory model ----------------
    logic [15:0] mem [64];
    logic        wen, rmode, dout, sk_s;
    logic [24:0] shs;
    logic [15:0] rsh_s;
    logic [8:0]  last_hdr;
    int          bcnt_s, busy;
    logic        stuck = 1'b0;

    assign do_in = rmode ? dout : ((busy != 0 || stuck) ? 1'b0 : 1'b1);

    always @(posedge clk) begin : model
        logic [24:0] n;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            wen <= 0; rmode <= 0; dout <= 0; sk_s <= 0; shs <= '0; rsh_s <= '0;
            last_hdr <= '0; bcnt_s <= 0; busy <= 0;
        end else begin
            sk_s <= sk;
            if (busy != 0) busy <= busy - 1;
            if (!cs) begin
                bcnt_s <= 0; rmode <= 0;
            end else if (sk && !sk_s) begin
                if (rmode) begin
                    dout <= rsh_s[15];
                    rsh_s <= {rsh_s[14:0], 1'b0};
                end else if (bcnt_s != 0 || di) begin
                    n = {shs[23:0], di};
                    shs <= n;
                    bcnt_s <= bcnt_s + 1;
                    if (bcnt_s == 8) begin
                        last_hdr <= n[8:0];
                        case (n[7:6])
                            2'b10: begin rmode <= 1; dout <= 0; rsh_s <= mem[n[5:0]]; end
                            2'b11: if (wen) begin mem[n[5:0]] <= 16'hFFFF; busy <= BUSY; end
                            2'b00: case (n[5:4])
                                2'b11: wen <= 1;
                                2'b00: wen <= 0;
                                2'b10: if (wen) begin
                                    for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
                                    busy <= BUSY;
                                end
                                default: ;
                            endcase
                            default: ;
                        endcase
                    end
                    if (bcnt_s == 24 && wen) begin
                        if (n[23:22] == 2'b01) begin
                            mem[n[21:16]] <= n[15:0]; busy <= BUSY;
                        end else if (n[23:22] == 2'b00 && n[21:20] == 2'b01) begin
                            for (int i = 0; i < 64; i++) mem[i] <= n[15:0];
                            busy <= BUSY;
                        end
                    end
                end
            end
        end
    end

    // ---------------- port monitors ----------------
    int cyc_cnt = 0, done_cnt = 0, cs_rises = 0;
    int low_len = 0, ph_len = 0;
    int v_gap = 0, v_ph = 0, v_skcs = 0, v_di = 0;
    logic cs_m = 0, sk_m = 0, di_m = 0;

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (rst_n) begin
            cs_m <= cs; sk_m <= sk; di_m <= di;
            if (done) done_cnt <= done_cnt + 1;
            if (cs && !cs_m) begin
                cs_rises <= cs_rises + 1;
                if (low_len < HALF) v_gap <= v_gap + 1;           // R8
            end
            low_len <= cs ? 0 : low_len + 1;
            if (sk !== sk_m || (cs && !cs_m)) ph_len <= 1; else ph_len <= ph_len + 1;
            if (sk !== sk_m && cs && cs_m && ph_len != HALF) v_ph <= v_ph + 1;   // R3
            if (sk && !cs) v_skcs <= v_skcs + 1;                                 // R3
            if (di !== di_m && cs && cs_m && !(sk_m && !sk)) v_di <= v_di + 1;   // R4
        end
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0;
    logic [15:0] refm [64];
    logic ren = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_hdr(logic [2:0] op, logic [5:0] a);
        case (op)
            3'd0: return {3'b110, a};
            3'd1: return {3'b101, a};
            3'd2: return {3'b111, a};
            3'd3: return {3'b100, 6'b110000};
            3'd5: return {3'b100, 6'b100000};
            3'd6: return {3'b100, 6'b010000};
            default: return {3'b100, 6'b000000};
        endcase
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output logic er, output int dn,
                           output int rises, output int cyc);
        int t0, d0, r0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1;
        d0 = done_cnt; r0 = cs_rises; t0 = cyc_cnt;
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        rd = rd_data; er = err_timeout; cyc = cyc_cnt - t0;
        @(negedge clk);
        dn = done_cnt - d0; rises = cs_rises - r0;
    endtask

    task automatic do_vec(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
        logic [15:0] rd; logic er; int dn, rises, cyc; bit prog;
        run_cmd(op, a, d, rd, er, dn, rises, cyc);
        prog = (op == 3'd1) || (op == 3'd2) || (op == 3'd5) || (op == 3'd6);
        chk(dn == 1, "R1 one done per command", dn, 1);
        chk(last_hdr == exp_hdr(op, a), "R2 frame header", last_hdr, exp_hdr(op, a));
        chk(er == 0, "R7 no timeout", er, 0);
        chk(rises == (prog ? 2 : 1), "R6/R9 CS windows", rises, prog ? 2 : 1);
        case (op)
            3'd0: chk(rd == refm[a], "R5 read data", rd, refm[a]);
            3'd1: if (ren) refm[a] = d;
            3'd2: if (ren) refm[a] = 16'hFFFF;
            3'd3: ren = 1;
            3'd5: if (ren) for (int i = 0; i < 64; i++) refm[i] = 16'hFFFF;
            3'd6: if (ren) for (int i = 0; i < 64; i++) refm[i] = d;
            default: ren = 0;
        endcase
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin : stim
        logic [15:0] rd; logic er; int dn, rises, cyc, d0;
        for (int i = 0; i < 64; i++) refm[i] = init_val(i);
        repeat (5) @(negedge clk);
        // reset state
        chk(cmd_ready == 1, "R1 ready in reset", cmd_ready, 1);
        chk(done == 0, "R1 no done in reset", done, 0);
        chk({cs, sk, di} == 3'b000, "R3 serial lines idle in reset", {cs, sk, di}, 0);
        chk(err_timeout == 0, "R7 no error in reset", err_timeout, 0);
        chk(rd_data == 0, "R5 read data cleared", rd_data, 0);
        rst_n = 1;

        for (int v = 0; v < NV; v++)
            do_vec(VEC[v][24:22], VEC[v][21:16], VEC[v][15:0]);

        // refused command while busy (R1)
        do_vec(3'd3, 6'd0, 16'h0);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 6'd20; cmd_wdata = 16'h1111; cmd_valid = 1;
        d0 = done_cnt;
        @(negedge clk); cmd_valid = 0;
        repeat (200) @(negedge clk);
        chk(cmd_ready == 0, "R1 busy mid-frame", cmd_ready, 0);
        cmd_addr = 6'd21; cmd_wdata = 16'h2222; cmd_valid = 1;
        @(negedge clk); cmd_valid = 0;
        while (!done) @(negedge clk);
        repeat (HALF * 8) @(negedge clk);
        chk(done_cnt - d0 == 1, "R1 refused request gives no done", done_cnt - d0, 1);
        refm[20] = 16'h1111;
        do_vec(3'd0, 6'd21, 16'h0);
        do_vec(3'd0, 6'd20, 16'h0);

        // request in the done cycle (R1)
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 6'd30; cmd_wdata = 16'h3333; cmd_valid = 1;
        d0 = done_cnt;
        @(negedge clk); cmd_valid = 0;
        while (!done) @(negedge clk);
        cmd_op = 3'd0; cmd_addr = 6'd30; cmd_valid = 1;
        chk(cmd_ready == 0, "R1 not ready during done", cmd_ready, 0);
        @(negedge clk);
        chk(cmd_ready == 1, "R1 ready after done", cmd_ready, 1);
        @(negedge clk); cmd_valid = 0;
        chk(cmd_ready == 0, "R1 held request accepted once", cmd_ready, 0);
        while (!done) @(negedge clk);
        chk(rd_data == 16'h3333, "R5 back-to-back read", rd_data, 16'h3333);
        @(negedge clk);
        chk(done_cnt - d0 == 2, "R1 two done pulses", done_cnt - d0, 2);
        refm[30] = 16'h3333;

        // timeout (R7)
        stuck = 1;
        run_cmd(3'd2, 6'd1, 16'h0, rd, er, dn, rises, cyc);
        chk(er == 1, "R7 timeout flagged", er, 1);
        chk(cyc >= TMO, "R7 polled for full bound", cyc, TMO);
        chk(dn == 1, "R1 one done on timeout", dn, 1);
        refm[1] = 16'hFFFF;
        repeat (10) @(negedge clk);
        chk(err_timeout == 1, "R7 error held until next command", err_timeout, 1);
        stuck = 0;
        do_vec(3'd0, 6'd1, 16'h0);

        chk(v_gap == 0, "R8 CS low gap", v_gap, 0);
        chk(v_ph == 0, "R3 SK phase length", v_ph, 0);
        chk(v_skcs == 0, "R3 SK low with CS low", v_skcs, 0);
        chk(v_di == 0, "R4 DI moves on SK fall", v_di, 0);
        report();
        $finish;
    end

endmodule